// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block models a flow-through synchronous SRAM with a burst interface. Its memory array is split into byte lanes. Address, chip selects and write controls are registered on the rising clock edge. An access starts from either of two active-low address strobes: a processor strobe and a controller strobe. The processor strobe has priority, and it always opens a read. The controller strobe can write in the same cycle that it loads the address.

A two-bit wraparound burst counter steps the low address bits while the advance input is low. With `order_i` low it steps in linear order. With `order_i` high it steps in XOR (interleaved) order. Read data comes straight from the registered address, with no output register. A data-output-enable tells the surrounding logic when read data may be driven. That enable is forced off during write cycles, while deselected, for the first clock after leaving deselect, and during sleep. A sleep input parks the block after two clocks and releases it two clocks after it falls, and memory contents are kept throughout.

Top module: `burst_sram_model`

## Requirements
- R1: When a strobe is acted on, the address is captured at that edge, and `rdata_o` shows the word at that address from that edge on (flow-through, no extra stage).
- R2: The processor strobe is ignored while `sel_a_ni` is high. If both strobes are low, only the processor strobe is acted on, and the cycle is a read even if write controls are asserted.
- R3: The clock that loads an address through the processor strobe never writes. On later clocks of that access, asserted write controls write to the current burst address, using the address after any advance at that edge.
- R4: The controller strobe writes `wdata_i` to `addr_i` at the same edge when the processor strobe is high, the chip selects are active and a write is indicated.
- R5: A write is indicated by `wr_all_ni` low, which writes all four lanes, or by `wr_en_ni` low with at least one `lane_ni[k]` low, which writes lane k at `wdata_i[9k+8:9k]`. `lane_ni` has no effect while `wr_en_ni` is high.
- R6: The burst counter loads from `addr_i[1:0]` on a strobe. It steps when `adv_ni` is low, holds when `adv_ni` is high, and wraps within an aligned group of four. The upper address bits never change during a burst.
- R7: With `order_i`=0 the n-th burst address low bits are (start+n) mod 4; for example, start 01 gives 01,10,11,00. With `order_i`=1 they are start XOR n; for example, start 01 gives 01,00,11,10.
- R8: `rdata_oe_o` is high only when the block is selected, `out_en_ni` is low, the previous edge did not write, and the previous edge did not load a selecting address while the block was deselected.
- R9: A strobe loaded with any chip select inactive (`sel_a_ni` high, `sel_b_i` low or `sel_c_ni` high) deselects the block. While deselected, no write takes place and the output stays disabled until a selecting load.
- R10: When `sleep_i` is high at two consecutive edges, the block is asleep. Asleep means the output is disabled, strobes and writes are ignored, and the selection is dropped. Two edges with `sleep_i` low wake it. Memory is preserved.
- R11: Reset clears selection, burst state and sleep state, which disables the output. Reset leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| proc_stb_ni | input | 1 | Processor address strobe, active low |
| ctrl_stb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| sel_a_ni | input | 1 | Chip select A, active low, also gates the processor strobe |
| sel_b_i | input | 1 | Chip select B, active high |
| sel_c_ni | input | 1 | Chip select C, active low |
| wr_all_ni | input | 1 | Write all lanes, active low |
| wr_en_ni | input | 1 | Lane write enable, active low |
| lane_ni | input | NB | Per-lane write selects, active low |
| out_en_ni | input | 1 | Output enable, active low, unclocked |
| order_i | input | 1 | Burst order: 0 linear, 1 XOR |
| sleep_i | input | 1 | Sleep request, active high |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Flow-through read data |
| rdata_oe_o | output | 1 | Read data may be driven |

## Verification
The assertions assume that `order_i` does not change while a burst is in progress. They also assume that `sleep_i` is low while reset is released, so the sleep pipeline starts from a known history. The stimulus keeps `order_i` fixed inside every burst. It toggles sleep only with both strobes idle and waits two clocks after wake before issuing a strobe. Before any read, it fills the array through controller-strobe writes, so every compared word is defined.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  function automatic logic [1:0] burst_bits(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input burst_order_e ord);
    return (ord == ORD_XOR) ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_sram_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       step_i,
  input  logic       order_i,
  input  logic [1:0] start_i,
  output logic [1:0] cur_bits_o,
  output logic [1:0] nxt_bits_o
);
  logic [1:0] start_q, cnt_q, cnt_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 2'd0;
      cnt_q   <= 2'd0;
    end else if (load_i) begin
      start_q <= start_i;
      cnt_q   <= 2'd0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  assign cnt_nxt    = step_i ? cnt_q + 2'd1 : cnt_q;
  assign cur_bits_o = burst_bits(start_q, cnt_q, burst_order_e'(order_i));
  assign nxt_bits_o = burst_bits(start_q, cnt_nxt, burst_order_e'(order_i));

  // R6
  hold_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> ($stable(cur_bits_o) || !$stable(order_i)));
  // R6
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cur_bits_o == $past(start_i)));
  // R7
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !order_i) |=>
      ((cur_bits_o == $past(cur_bits_o) + 2'd1) || order_i));
  // R7
  xor_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && order_i) |=>
      (((cur_bits_o ^ start_q) == (($past(cur_bits_o) ^ start_q) + 2'd1)) || !order_i));
endmodule

// File: rtl/write_qual.sv
module write_qual #(
  parameter int NB = 4
)(
  input  logic          wr_all_ni,
  input  logic          wr_en_ni,
  input  logic [NB-1:0] lane_ni,
  output logic          wr_any_o,
  output logic [NB-1:0] mask_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign mask_o[g] = !wr_all_ni || (!wr_en_ni && !lane_ni[g]);
  end
  assign wr_any_o = |mask_o;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int DEPTH = 256,
  parameter int NB    = 4,
  parameter int LW    = 9,
  parameter int AW    = $clog2(DEPTH)
)(
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [NB-1:0]    wmask_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [NB*LW-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [NB*LW-1:0] rdata_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[g]) mem[waddr_i] <= wdata_i[g*LW +: LW];
    end
    assign rdata_o[g*LW +: LW] = mem[raddr_i];
  end
endmodule

// File: rtl/burst_sram_model.sv
module burst_sram_model
  import burst_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int NB    = 4,
  parameter int LW    = 9,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = NB * LW
)(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          proc_stb_ni,
  input  logic          ctrl_stb_ni,
  input  logic          adv_ni,
  input  logic          sel_a_ni,
  input  logic          sel_b_i,
  input  logic          sel_c_ni,
  input  logic          wr_all_ni,
  input  logic          wr_en_ni,
  input  logic [NB-1:0] lane_ni,
  input  logic          out_en_ni,
  input  logic          order_i,
  input  logic          sleep_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_oe_o
);
  localparam int HW = AW - 2;

  logic          awake, en_ok, proc_go, ctrl_go, load, step;
  logic          wr_any, load_wr, cont_wr, mem_we;
  logic [NB-1:0] wr_mask;
  logic [1:0]    cur_bits, nxt_bits;
  logic [HW-1:0] base_q;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          sel_q, first_q, wr_q;
  logic [1:0]    zz_q;

  assign awake   = !zz_q[1];
  assign en_ok   = !sel_a_ni && sel_b_i && !sel_c_ni;
  // processor strobe wins; gated by select A
  assign proc_go = awake && !proc_stb_ni && !sel_a_ni;
  assign ctrl_go = awake && !ctrl_stb_ni && proc_stb_ni;
  assign load    = proc_go || ctrl_go;
  assign step    = awake && !load && sel_q && !adv_ni;

  write_qual #(.NB(NB)) u_wq (
    .wr_all_ni (wr_all_ni),
    .wr_en_ni  (wr_en_ni),
    .lane_ni   (lane_ni),
    .wr_any_o  (wr_any),
    .mask_o    (wr_mask)
  );

  assign load_wr = ctrl_go && en_ok && wr_any;
  assign cont_wr = awake && !load && sel_q && wr_any;
  assign mem_we  = load_wr || cont_wr;

  burst_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .order_i    (order_i),
    .start_i    (addr_i[1:0]),
    .cur_bits_o (cur_bits),
    .nxt_bits_o (nxt_bits)
  );

  assign rd_addr = {base_q, cur_bits};
  assign wr_addr = load_wr ? addr_i : {base_q, nxt_bits};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      sel_q   <= 1'b0;
      first_q <= 1'b0;
      wr_q    <= 1'b0;
      zz_q    <= 2'b00;
    end else begin
      zz_q <= {zz_q[0], sleep_i};
      wr_q <= mem_we;
      if (!awake) begin
        sel_q   <= 1'b0;
        first_q <= 1'b0;
      end else if (load) begin
        base_q  <= addr_i[AW-1:2];
        first_q <= en_ok && !sel_q;
        sel_q   <= en_ok;
      end else begin
        first_q <= 1'b0;
      end
    end
  end

  sram_array #(.DEPTH(DEPTH), .NB(NB), .LW(LW), .AW(AW)) u_arr (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .wmask_i (wr_mask),
    .waddr_i (wr_addr),
    .wdata_i (wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (rdata_o)
  );

  // output enable is unclocked in out_en_ni
  assign rdata_oe_o = sel_q && !wr_q && !first_q && !out_en_ni && awake;

  // R1
  capture_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (rd_addr == $past(addr_i)));
  // R2
  proc_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && !proc_stb_ni && sel_a_ni && adv_ni) |=> ($stable(rd_addr) && $stable(sel_q)));
  // R8
  write_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> !rdata_oe_o);
  // R8
  first_clk_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && load && en_ok && !sel_q) |=> !rdata_oe_o);
  // R9
  deselect_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && load && !en_ok) |=> (!rdata_oe_o && !sel_q));
  // R10
  sleep_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sleep_i)) |=> !rdata_oe_o);
endmodule

// File: tb/burst_sram_model_test.sv
module burst_sram_model_test;
  localparam int DEPTH = 256;
  localparam int NB    = 4;
  localparam int LW    = 9;
  localparam int AW    = 8;
  localparam int DW    = 36;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
  logic sa_n = 1'b0, sb = 1'b1, sc_n = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [NB-1:0] lane_n = '1;
  logic oe_n = 1'b0, ord = 1'b0, slp = 1'b0;
  logic [DW-1:0] wdat = '0;
  logic [DW-1:0] rdata_o;
  logic rdata_oe_o;

  always #10 clk = ~clk;

  burst_sram_model uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr),
    .proc_stb_ni(pstb_n), .ctrl_stb_ni(cstb_n), .adv_ni(adv_n),
    .sel_a_ni(sa_n), .sel_b_i(sb), .sel_c_ni(sc_n),
    .wr_all_ni(gw_n), .wr_en_ni(bwe_n), .lane_ni(lane_n),
    .out_en_ni(oe_n), .order_i(ord), .sleep_i(slp), .wdata_i(wdat),
    .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R11";

  // reference model
  logic [DW-1:0] mm [DEPTH];
  bit m_sel, m_first, m_wr, m_asleep, m_s1;
  int m_base, m_start, m_n;

  function automatic logic [DW-1:0] pat(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {b + 8'd3, 1'b1, b ^ 8'hA5, 1'b0, ~b, 1'b1, b, 1'b0};
  endfunction

  function automatic int m_addr();
    int low;
    if (ord) low = m_start ^ m_n;
    else     low = (m_start + m_n) % 4;
    return (m_base / 4) * 4 + low;
  endfunction

  task automatic m_write(input int a, input logic [NB-1:0] lm);
    for (int k = 0; k < NB; k++)
      if (lm[k]) mm[a][k*LW +: LW] = wdat[k*LW +: LW];
  endtask

  task automatic model_step();
    bit ps, cs, en, wd;
    logic [NB-1:0] lm;
    ps = !pstb_n && !sa_n;
    cs = !cstb_n && pstb_n;
    en = !sa_n && sb && !sc_n;
    lm = !gw_n ? '1 : (!bwe_n ? ~lane_n : '0);
    wd = (lm != 0);
    if (m_asleep) begin
      m_sel = 0; m_first = 0; m_wr = 0;
    end else if (ps || cs) begin
      m_first = en && !m_sel;
      m_sel = en; m_base = int'(addr); m_start = int'(addr) % 4; m_n = 0; m_wr = 0;
      if (cs && en && wd) begin m_write(int'(addr), lm); m_wr = 1; end
    end else begin
      m_first = 0; m_wr = 0;
      if (m_sel) begin
        if (!adv_n) m_n = (m_n + 1) % 4;
        if (wd) begin m_write(m_addr(), lm); m_wr = 1; end
      end
    end
    m_asleep = m_s1;
    m_s1 = slp;
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit exp_oe;
    exp_oe = m_sel && !m_wr && !m_first && !oe_n && !m_asleep;
    check(tag, "oe", 64'(rdata_oe_o), 64'(exp_oe));
    if (m_sel) check(tag, "rdata", 64'(rdata_o), 64'(mm[m_addr()]));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    pstb_n = 1; cstb_n = 1; adv_n = 1; sa_n = 0; sb = 1; sc_n = 0;
    gw_n = 1; bwe_n = 1; lane_n = '1; oe_n = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (3) @(posedge clk);
    m_sel = 0; m_first = 0; m_wr = 0; m_asleep = 0; m_s1 = 0;
    m_base = 0; m_start = 0; m_n = 0;
    @(negedge clk);
    rst_ni = 1;
    check("R11", "oe after reset", 64'(rdata_oe_o), 64'd0);
  endtask

  task automatic ctrl_read(input int a);
    idle(); cstb_n = 0; addr = a[AW-1:0];
    cyc();
    idle();
  endtask

  initial begin
    logic [DW-1:0] d1, d2, exp5;
    int lin [4];
    int xr [4];
    idle();
    do_reset();

    // R4: fill through controller-strobe writes
    tag = "R4";
    for (int i = 0; i < DEPTH; i++) begin
      idle(); cstb_n = 0; gw_n = 0; addr = i[AW-1:0]; wdat = pat(i);
      cyc();
    end
    idle(); cyc();
    // R1: capture and flow-through
    tag = "R1";
    ctrl_read(8'h37);
    check("R1", "flow-through read", 64'(rdata_o), 64'(pat(8'h37)));
    cyc();

    // R7 linear, R6 wrap and suspend
    tag = "R7"; ord = 0;
    lin = '{8'h11, 8'h12, 8'h13, 8'h10};
    idle(); pstb_n = 0; addr = 8'h11; cyc();
    check("R7", "linear 0", 64'(rdata_o), 64'(pat(lin[0])));
    for (int k = 1; k < 4; k++) begin
      idle(); adv_n = 0; cyc();
      check("R7", "linear step", 64'(rdata_o), 64'(pat(lin[k])));
    end
    tag = "R6";
    idle(); adv_n = 0; cyc();
    check("R6", "wrap to start", 64'(rdata_o), 64'(pat(8'h11)));
    idle(); cyc();
    check("R6", "suspend holds", 64'(rdata_o), 64'(pat(8'h11)));

    // R7 XOR order
    tag = "R7"; ord = 1;
    xr = '{8'h11, 8'h10, 8'h13, 8'h12};
    idle(); pstb_n = 0; addr = 8'h11; cyc();
    for (int k = 1; k < 4; k++) begin
      idle(); adv_n = 0; cyc();
      check("R7", "xor step", 64'(rdata_o), 64'(pat(xr[k])));
    end
    idle(); pstb_n = 0; addr = 8'h12; cyc();
    idle(); adv_n = 0; cyc();
    check("R7", "xor start 2 step 1", 64'(rdata_o), 64'(pat(8'h13)));
    idle(); adv_n = 0; cyc();
    check("R7", "xor start 2 step 2", 64'(rdata_o), 64'(pat(8'h10)));
    ord = 0;

    // R2: processor strobe gated by select A, priority over controller strobe
    tag = "R2";
    idle(); pstb_n = 0; addr = 8'h30; cyc();
    idle(); pstb_n = 0; sa_n = 1; addr = 8'h50; cyc();
    check("R2", "gated strobe ignored", 64'(rdata_o), 64'(pat(8'h30)));
    idle(); pstb_n = 0; cstb_n = 0; gw_n = 0; wdat = '0; addr = 8'h51; cyc();
    check("R2", "priority read", 64'(rdata_o), 64'(pat(8'h51)));
    idle(); cyc();
    check("R2", "no write on priority", 64'(rdata_o), 64'(pat(8'h51)));

    // R3: processor-started access writes only on later clocks
    tag = "R3";
    d1 = 36'h1_2345_6789; d2 = 36'hF_EDCB_A987;
    idle(); pstb_n = 0; gw_n = 0; wdat = d1; addr = 8'h40; cyc();
    check("R3", "first clock is read", 64'(rdata_o), 64'(pat(8'h40)));
    idle(); gw_n = 0; wdat = d1; cyc();
    check("R3", "suspend write", 64'(rdata_o), 64'(d1));
    check("R8", "oe off in write", 64'(rdata_oe_o), 64'd0);
    idle(); gw_n = 0; adv_n = 0; wdat = d2; cyc();
    check("R3", "advance write", 64'(rdata_o), 64'(d2));
    idle(); cyc();
    check("R8", "oe back after write", 64'(rdata_oe_o), 64'd1);

    // R5: lane writes
    tag = "R5";
    idle(); cstb_n = 0; bwe_n = 0; lane_n = 4'b1010; wdat = '1; addr = 8'h20; cyc();
    exp5 = pat(8'h20);
    exp5[8:0] = 9'h1FF; exp5[26:18] = 9'h1FF;
    ctrl_read(8'h20);
    check("R5", "lanes 0 and 2", 64'(rdata_o), 64'(exp5));
    idle(); cstb_n = 0; lane_n = 4'b0000; wdat = '0; addr = 8'h21; cyc();
    check("R5", "selects without enable", 64'(rdata_o), 64'(pat(8'h21)));
    check("R5", "treated as read", 64'(rdata_oe_o), 64'd1);
    idle(); cyc();

    // R9: deselect, then R8 first-clock mask
    tag = "R9";
    idle(); cstb_n = 0; sb = 0; gw_n = 0; wdat = '0; addr = 8'h22; cyc();
    check("R9", "oe off deselected", 64'(rdata_oe_o), 64'd0);
    idle(); gw_n = 0; adv_n = 0; cyc();
    idle(); cyc();
    tag = "R8";
    ctrl_read(8'h22);
    check("R9", "no write while deselected", 64'(rdata_o), 64'(pat(8'h22)));
    check("R8", "first clock masked", 64'(rdata_oe_o), 64'd0);
    cyc();
    check("R8", "oe after first clock", 64'(rdata_oe_o), 64'd1);
    oe_n = 1; #1;
    check("R8", "oe input high", 64'(rdata_oe_o), 64'd0);
    idle(); cyc();

    // R10: sleep entry and exit
    tag = "R10";
    slp = 1; cyc(); cyc();
    check("R10", "asleep after two clocks", 64'(rdata_oe_o), 64'd0);
    idle(); cstb_n = 0; gw_n = 0; wdat = '0; addr = 8'h23; cyc();
    idle(); cyc();
    slp = 0; cyc(); cyc();
    ctrl_read(8'h23);
    check("R10", "memory kept, write ignored", 64'(rdata_o), 64'(pat(8'h23)));
    cyc();
    check("R10", "awake oe", 64'(rdata_oe_o), 64'd1);

    // R11: reset keeps array
    tag = "R11";
    do_reset();
    ctrl_read(8'h41);
    check("R11", "array survives reset", 64'(rdata_o), 64'(d2));
    cyc();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule